// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor that finishes one instruction in every clock cycle. It implements a small integer subset of a classic 32-bit load/store instruction set. That subset covers three-register arithmetic and set-on-less-than, immediate arithmetic and logic, a load-upper for building constants, word loads and stores, two compare-and-branch forms and a region-limited jump. The core holds its own program counter, next-PC selection, a 32 x 32-bit register file with a hardwired zero register, an ALU, immediate extension and the decoder. It also keeps small word arrays for program and data storage.

A program is written into the program store through a word-wide load port while reset is held. After reset is released, execution starts at address 0. Stores are visible at the block's ports in the cycle they execute. A system, or a bench, can therefore follow every memory write the program makes.

Top module: `mini_risc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `st_en` is 0. Execution begins at byte address 0 when reset is released.
- R2: Opcode 0 selects a register-format instruction with fields op[31:26], rs[25:21], rt[20:16] and rd[15:11], and function code [5:0]. Function 32 writes rs+rt to rd and function 34 writes rs-rt to rd.
- R3: Function 42 (register form) and opcode 10 (immediate form) write 1 to the destination when rs is less than the second operand as signed numbers, and 0 otherwise.
- R4: The immediate field is bits [15:0]. Opcodes 8 (add immediate), 10, 35 and 43 sign-extend it, while opcodes 12 (AND immediate) and 13 (OR immediate) zero-extend it. Immediate-format results go to rt.
- R5: Opcode 15 writes the immediate into bits [31:16] of rt and zeros into bits [15:0]. A following OR-immediate then completes a full 32-bit constant.
- R6: Opcode 43 stores rt at byte address rs+sext(imm). In that cycle it drives `st_en`=1, `st_addr` and `st_data`. Opcode 35 loads the word at rs+sext(imm) into rt. Negative offsets are honoured.
- R7: Opcode 4 (branch if equal) and opcode 5 (branch if not equal) go to PC+4+(sext(imm)<<2) when their condition holds, and to PC+4 otherwise.
- R8: Opcode 2 jumps to {PC+4[31:28], bits[25:0], 2'b00}.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: Every instruction that does not redirect the flow advances the PC by exactly 4 in one clock cycle.
- R11: While `ld_we` is high, `ld_data` is written to program word `ld_addr` on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_we | input | 1 | Program store write enable |
| ld_addr | input | $clog2(IMEM_WORDS) | Program store word index |
| ld_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| st_en | output | 1 | A store executes this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
The bench builds the core with a 64-word program store and a 16-word data store. With 64 program words there is room for a jump that skips a block of stores and for a backward-branch loop. With 16 data words every store slot the program uses is covered without wrapping. The program covers negative immediates, constants with bit 15 set (to separate zero-extension from sign-extension), signed comparisons, writes aimed at register 0, and both taken and not-taken branches.

// File: rtl/mini_risc_core.sv
module mini_risc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_we,
  input  logic [IAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  output logic [31:0]    pc_o,
  output logic           st_en,
  output logic [31:0]    st_addr,
  output logic [31:0]    st_data
);

  localparam logic [5:0] OP_RT = 6'd0,  OP_J = 6'd2,  OP_BEQ = 6'd4, OP_BNE = 6'd5,
                         OP_ADDI = 6'd8, OP_SLTI = 6'd10, OP_ANDI = 6'd12,
                         OP_ORI = 6'd13, OP_LUI = 6'd15, OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [5:0] FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

  typedef enum logic [2:0] {A_ADD, A_SUB, A_SLT, A_AND, A_OR, A_LUI} alu_op_t;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  logic [31:0] pc_q, instr, rs_val, rt_val, imm_ext, imm_sx, opb, alu_y, wb_val;
  logic [31:0] pc4, br_tgt, j_tgt;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, wdst;
  logic [15:0] imm;
  logic        reg_we, dst_rd, use_imm, zext, ld_op, sw_op, beq_op, bne_op, j_op, take_br;
  alu_op_t     aop;

  assign instr = imem[pc_q[IAW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign fn    = instr[5:0];
  assign imm   = instr[15:0];

  always_comb begin
    reg_we = 1'b0; dst_rd = 1'b0; use_imm = 1'b1; zext = 1'b0; aop = A_ADD;
    ld_op = 1'b0; sw_op = 1'b0; beq_op = 1'b0; bne_op = 1'b0; j_op = 1'b0;
    case (op)
      OP_RT: begin
        use_imm = 1'b0;
        dst_rd  = 1'b1;
        case (fn)
          FN_ADD: begin reg_we = 1'b1; aop = A_ADD; end
          FN_SUB: begin reg_we = 1'b1; aop = A_SUB; end
          FN_SLT: begin reg_we = 1'b1; aop = A_SLT; end
          default: reg_we = 1'b0;
        endcase
      end
      OP_ADDI: reg_we = 1'b1;
      OP_SLTI: begin reg_we = 1'b1; aop = A_SLT; end
      OP_ANDI: begin reg_we = 1'b1; aop = A_AND; zext = 1'b1; end
      OP_ORI:  begin reg_we = 1'b1; aop = A_OR;  zext = 1'b1; end
      OP_LUI:  begin reg_we = 1'b1; aop = A_LUI; end
      OP_LW:   begin reg_we = 1'b1; ld_op = 1'b1; end
      OP_SW:   sw_op = 1'b1;
      OP_BEQ:  begin beq_op = 1'b1; use_imm = 1'b0; end
      OP_BNE:  begin bne_op = 1'b1; use_imm = 1'b0; end
      OP_J:    j_op = 1'b1;
      default: reg_we = 1'b0;
    endcase
  end

  assign rs_val  = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val  = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign imm_sx  = {{16{imm[15]}}, imm};
  assign imm_ext = zext ? {16'd0, imm} : imm_sx;
  assign opb     = use_imm ? imm_ext : rt_val;

  always_comb begin
    case (aop)
      A_SUB:   alu_y = rs_val - opb;
      A_SLT:   alu_y = {31'd0, $signed(rs_val) < $signed(opb)};
      A_AND:   alu_y = rs_val & opb;
      A_OR:    alu_y = rs_val | opb;
      A_LUI:   alu_y = {imm, 16'd0};
      default: alu_y = rs_val + opb;
    endcase
  end

  assign wb_val = ld_op ? dmem[alu_y[DAW+1:2]] : alu_y;
  assign wdst   = dst_rd ? rd : rt;

  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + {imm_sx[29:0], 2'b00};
  assign j_tgt   = {pc4[31:28], instr[25:0], 2'b00};
  assign take_br = (beq_op && rs_val == rt_val) || (bne_op && rs_val != rt_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= 32'd0;
    else if (j_op)    pc_q <= j_tgt;
    else if (take_br) pc_q <= br_tgt;
    else              pc_q <= pc4;
  end

  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_addr] <= ld_data;
    if (st_en) dmem[alu_y[DAW+1:2]] <= rt_val;
    if (rst_n && reg_we && wdst != 5'd0) rf[wdst] <= wb_val;
  end

  assign pc_o    = pc_q;
  assign st_en   = rst_n && sw_op;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!st_en && pc_o == 32'd0));

  // R10
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!j_op && !beq_op && !bne_op) |=> pc_o == $past(pc_o) + 32'd4);

  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |=> pc_o == $past(pc_o) + 32'd4 + {$past(imm_sx[29:0]), 2'b00});

  // R8
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    j_op |=> (pc_o[27:2] == $past(instr[25:0]) && pc_o[1:0] == 2'b00));

endmodule

// File: tb/test_mini_risc_core.sv
module test_mini_risc_core;
  localparam int IMW = 64;
  localparam int DMW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [5:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, st_addr, st_data;
  logic st_en;

  always #2.5 clk = ~clk;

  mini_risc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) i_mini_risc_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .st_en(st_en), .st_addr(st_addr), .st_data(st_data));

  int checks = 0;
  int fails = 0;

  logic [31:0] prog [IMW];
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DMW];
  logic [31:0] seen [DMW];
  logic [31:0] m_pc;
  int n_st = 0;
  bit pc_skip_bad = 0;
  bit pc_j_bad = 0;

  function automatic logic [31:0] enc_r(int fnc, int s, int t, int d);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fnc)};
  endfunction
  function automatic logic [31:0] enc_i(int o, int s, int t, int im);
    return {6'(o), 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] enc_j(int a);
    return {6'd2, 26'(a)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_cycle();
    logic [31:0] ins, a, b, sx, zx, res, nxt;
    int o, s, t, d, f;
    bit we;
    ins = prog[m_pc[7:2]];
    o = int'(ins[31:26]); s = int'(ins[25:21]); t = int'(ins[20:16]);
    d = int'(ins[15:11]); f = int'(ins[5:0]);
    a = m_rf[s]; b = m_rf[t];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    nxt = m_pc + 4;
    we = 0; res = 0;
    chk(pc_o == m_pc, "R10 pc", pc_o, m_pc);
    if (o == 43) begin
      chk(st_en == 1'b1, "R6 st_en", {31'd0, st_en}, 1);
      chk(st_addr == a + sx, "R6 st_addr", st_addr, a + sx);
      chk(st_data == b, "R6 st_data", st_data, b);
      m_dm[(a + sx) >> 2 & (DMW - 1)] = b;
    end else begin
      chk(st_en == 1'b0, "R6 no store", {31'd0, st_en}, 0);
    end
    if (st_en) begin
      seen[st_addr[5:2]] = st_data;
      n_st++;
    end
    case (o)
      0: begin
        we = 1; t = d;
        if (f == 32) res = a + b;
        else if (f == 34) res = a - b;
        else if (f == 42) res = ($signed(a) < $signed(b)) ? 1 : 0;
        else we = 0;
      end
      8:  begin we = 1; res = a + sx; end
      10: begin we = 1; res = ($signed(a) < $signed(sx)) ? 1 : 0; end
      12: begin we = 1; res = a & zx; end
      13: begin we = 1; res = a | zx; end
      15: begin we = 1; res = {ins[15:0], 16'd0}; end
      35: begin we = 1; res = m_dm[(a + sx) >> 2 & (DMW - 1)]; end
      4:  if (a == b) nxt = m_pc + 4 + (sx << 2);
      5:  if (a != b) nxt = m_pc + 4 + (sx << 2);
      2:  nxt = {nxt[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    if (we && t != 0) m_rf[t] = res;
    m_pc = nxt;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < IMW; i++) prog[i] = enc_j(i);
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    for (int i = 0; i < DMW; i++) begin m_dm[i] = 0; seen[i] = 32'hDEADBEEF; end
    prog[0]  = enc_i(8, 0, 1, 5);
    prog[1]  = enc_i(8, 0, 2, -3);
    prog[2]  = enc_r(32, 1, 2, 3);
    prog[3]  = enc_r(34, 2, 1, 4);
    prog[4]  = enc_r(42, 2, 1, 5);
    prog[5]  = enc_r(42, 1, 2, 6);
    prog[6]  = enc_i(10, 2, 7, -2);
    prog[7]  = enc_i(15, 0, 8, 16'hABCD);
    prog[8]  = enc_i(13, 8, 8, 16'h8765);
    prog[9]  = enc_i(12, 2, 9, 16'hFFF0);
    prog[10] = enc_i(8, 0, 0, 7);
    prog[11] = enc_r(32, 0, 0, 10);
    prog[12] = enc_i(43, 0, 3, 0);
    prog[13] = enc_i(43, 0, 4, 4);
    prog[14] = enc_i(43, 0, 5, 8);
    prog[15] = enc_i(43, 0, 7, 12);
    prog[16] = enc_i(43, 0, 8, 16);
    prog[17] = enc_i(43, 0, 9, 20);
    prog[18] = enc_i(43, 0, 10, 24);
    prog[19] = enc_i(8, 0, 11, 40);
    prog[20] = enc_i(43, 11, 1, -8);
    prog[21] = enc_i(35, 11, 12, -8);
    prog[22] = enc_i(43, 0, 12, 36);
    prog[23] = enc_i(4, 1, 12, 2);
    prog[24] = enc_i(43, 0, 0, 4);
    prog[25] = enc_i(43, 0, 0, 8);
    prog[26] = enc_i(5, 1, 12, 5);
    prog[27] = enc_i(8, 0, 13, 3);
    prog[28] = enc_i(8, 13, 13, -1);
    prog[29] = enc_i(5, 13, 0, -2);
    prog[30] = enc_i(43, 0, 13, 40);
    prog[31] = enc_j(40);
    for (int i = 32; i < 40; i++) prog[i] = enc_i(43, 0, 1, 44);
    prog[40] = enc_i(43, 0, 8, 44);
    prog[41] = enc_j(41);

    // R2: encoder field placement against the known register-add word
    chk(enc_r(32, 17, 18, 9) == 32'h02324820, "R2 encoding", enc_r(32, 17, 18, 9), 32'h02324820);

    for (int i = 0; i < IMW; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 6'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    // R1: reset state
    chk(pc_o == 0, "R1 pc in reset", pc_o, 0);
    chk(st_en == 0, "R1 no store in reset", {31'd0, st_en}, 0);
    m_pc = 0;
    rst_n = 1'b1;
    #1;
    for (int c = 0; c < 60; c++) begin
      if (pc_o == 96 || pc_o == 100) pc_skip_bad = 1;
      if (pc_o >= 128 && pc_o < 160) pc_j_bad = 1;
      model_cycle();
      @(negedge clk);
    end
    chk(seen[0] == 2, "R2 add", seen[0], 2);
    chk(seen[1] == 32'hFFFFFFF8, "R2 sub / R4 sext", seen[1], 32'hFFFFFFF8);
    chk(seen[2] == 1, "R3 slt signed", seen[2], 1);
    chk(seen[3] == 1, "R3 slti", seen[3], 1);
    chk(seen[4] == 32'hABCD8765, "R5 lui+ori", seen[4], 32'hABCD8765);
    chk(seen[5] == 32'h0000FFF0, "R4 andi zext", seen[5], 32'h0000FFF0);
    chk(seen[6] == 0, "R9 reg0 write ignored", seen[6], 0);
    chk(seen[8] == 5, "R6 negative offset store", seen[8], 5);
    chk(seen[9] == 5, "R6 load", seen[9], 5);
    chk(seen[10] == 0, "R7 bne loop", seen[10], 0);
    chk(seen[11] == 32'hABCD8765, "R8 jump", seen[11], 32'hABCD8765);
    chk(!pc_skip_bad, "R7 beq skipped words", {31'd0, pc_skip_bad}, 0);
    chk(!pc_j_bad, "R8 jumped-over words", {31'd0, pc_j_bad}, 0);
    chk(pc_o == 164, "R8 spin target", pc_o, 164);
    chk(n_st == 11, "R11 loaded program store count", n_st, 11);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule